// File: doc/BRIEF.md
# Pixel Hit Timestamp Capture

This block is the digital half of a two-stage time-to-digital converter that sits in every pixel of a detector matrix. A master clock (nominally 160 MHz) drives a 10-bit coarse counter whose value reaches the pixel already Gray-encoded. When the hit discriminator fires, the pixel keeps a copy of that coarse word in a local register. At the same moment it raises a ramp-enable window for the analogue fine-time circuit.

The window closes on the first rising clock edge that comes after a falling clock edge. This guarantees a minimum analogue interval, so the fine range spans up to three clock periods and absorbs any mismatch between the coarse and fine stages. A run-down (Wilkinson) conversion follows. The block counts rising clock edges while the stored level discharges and stops when the run-down comparator trips. The count is 8 bits wide, which is enough for the 192 bins of 97.6 ps that fit in three periods. The result is issued as one 18-bit word with a single-cycle valid strobe and an overflow flag.

The ramp, the capacitor and the comparator are analogue and lie outside the block. Here they appear only as the `ramp_o` output and the `cmp_i` input. The hit input is taken as already aligned to the clock and is sampled on rising edges.

Top module: `pixel_tstamp_capture`

## Requirements
- R1: After reset, `busy_o`, `ramp_o`, `valid_o` and `ovf_o` are 0 and `word_o` is 0.
- R2: A rising edge of `hit_i`, seen on a rising clock edge while `busy_o` is 0, stores the value of `coarse_i` at that edge unchanged (still Gray-coded). Later changes of `coarse_i` do not alter the stored value.
- R3: `ramp_o` goes high on the clock edge that detects the hit. It goes low on the first rising edge that follows a falling edge while it is high. For a hit detected on a rising edge this makes the window exactly one clock period.
- R4: After the window closes, the fine value equals the number of rising edges at which `cmp_i` is sampled 0, counted up to the first rising edge at which `cmp_i` is sampled 1.
- R5: `valid_o` is high for exactly one cycle, starting at the edge after the one that samples the trip. At that point `word_o[17:8]` holds the stored Gray coarse value and `word_o[7:0]` holds the fine value. `word_o` and `ovf_o` then hold until the next result.
- R6: The fine count saturates at 255. `ovf_o` is 1 with a result only when at least 256 low samples were seen (255 gives fine 255 with `ovf_o` 0).
- R7: `busy_o` is high from the hit edge until the edge that samples the trip. A hit rising edge while busy is ignored: the stored coarse value does not change and no extra conversion starts. A hit held high past the end of a conversion starts nothing, because a new conversion needs a new rising edge.
- R8: `cmp_i` has no effect while the block is idle, so no `valid_o` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | 1 | Hit discriminator output, aligned to the clock |
| coarse_i | input | 10 | Distributed Gray-coded coarse time |
| cmp_i | input | 1 | Run-down comparator, 1 when the level has discharged |
| ramp_o | output | 1 | Fine-interval window, enables ramp charging |
| busy_o | output | 1 | Capture, window or run-down in progress |
| word_o | output | 18 | Result: Gray coarse in 17:8, fine count in 7:0 |
| valid_o | output | 1 | One-cycle strobe for a new result |
| ovf_o | output | 1 | Fine count saturated in the last result |

## Verification
The hardest case to reach is a hit that arrives while a run-down is already in progress and then stays high past the end of that conversion. The stimulus raises `hit_i` a few cycles into the run-down and also changes `coarse_i`. It keeps `hit_i` high until after `valid_o` has pulsed, so the bench can confirm that the result carries the first coarse value and that `busy_o` stays low afterwards. The saturation boundary is reached by holding the comparator low for 255 edges and then for 256 edges, which gives fine 255 both times but sets the overflow flag only the second time.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WINDOW  = 2'd1,
    PH_RUNDOWN = 2'd2
  } phase_t;
endpackage

// File: rtl/pts_coarse_latch.sv
module pts_coarse_latch #(
  parameter int COARSE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] gray_i,
  output logic [COARSE_W-1:0] gray_o
);
  logic [COARSE_W-1:0] gray_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gray_q <= '0;
    else if (load_i) gray_q <= gray_i;
  end

  assign gray_o = gray_q;

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(gray_o)); // R2
endmodule

// File: rtl/pts_window_ctrl.sv
module pts_window_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic win_o,
  output logic close_o
);
  logic win_q;
  logic fall_seen_q;

  // records that a falling edge has occurred with the window open
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_seen_q <= 1'b0;
    else        fall_seen_q <= win_q;
  end

  assign close_o = win_q & fall_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_q <= 1'b0;
    else if (close_o) win_q <= 1'b0;
    else if (start_i) win_q <= 1'b1;
  end

  assign win_o = win_q;

  AST_WIN_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_o) |-> $past(fall_seen_q)); // R3
  AST_WIN_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |=> !win_o); // R3
endmodule

// File: rtl/pts_rundown.sv
module pts_rundown #(
  parameter int FINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              cmp_i,
  output logic [FINE_W-1:0] cnt_o,
  output logic              ovf_o,
  output logic              trip_o
);
  localparam logic [FINE_W-1:0] CNT_MAX = {FINE_W{1'b1}};

  logic [FINE_W-1:0] cnt_q;
  logic              ovf_q;

  // saturating step: returns {overflow, next}
  function automatic logic [FINE_W:0] sat_step(input logic [FINE_W-1:0] v);
    if (v == CNT_MAX) return {1'b1, CNT_MAX};
    return {1'b0, v + 1'b1};
  endfunction

  logic [FINE_W:0] step_w;
  assign step_w = sat_step(cnt_q);
  assign trip_o = run_i & cmp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (!cmp_i) begin
      cnt_q <= step_w[FINE_W-1:0];
      ovf_q <= ovf_q | step_w[FINE_W];
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !cmp_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && ovf_q)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !cmp_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
endmodule

// File: rtl/pixel_tstamp_capture.sv
module pixel_tstamp_capture #(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hit_i,
  input  logic [COARSE_W-1:0]        coarse_i,
  input  logic                       cmp_i,
  output logic                       ramp_o,
  output logic                       busy_o,
  output logic [COARSE_W+FINE_W-1:0] word_o,
  output logic                       valid_o,
  output logic                       ovf_o
);
  import pts_pkg::*;
  localparam int WORD_W = COARSE_W + FINE_W;

  function automatic logic [WORD_W-1:0] pack_word(input logic [COARSE_W-1:0] g,
                                                   input logic [FINE_W-1:0] f);
    return {g, f};
  endfunction

  phase_t              phase_q;
  logic                hit_q;
  logic                hit_rise;
  logic                start_w;
  logic                win_w;
  logic                close_w;
  logic                run_w;
  logic                trip_w;
  logic [FINE_W-1:0]   fine_w;
  logic                fine_ovf_w;
  logic [COARSE_W-1:0] coarse_w;
  logic [WORD_W-1:0]   word_q;
  logic                valid_q;
  logic                ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_i;
  end

  assign hit_rise = hit_i & ~hit_q;
  assign start_w  = hit_rise & (phase_q == PH_IDLE);
  assign run_w    = (phase_q == PH_RUNDOWN);

  pts_coarse_latch #(.COARSE_W(COARSE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_i(start_w), .gray_i(coarse_i), .gray_o(coarse_w)
  );

  pts_window_ctrl u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .win_o(win_w), .close_o(close_w)
  );

  pts_rundown #(.FINE_W(FINE_W)) u_run (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .cmp_i(cmp_i),
    .cnt_o(fine_w), .ovf_o(fine_ovf_w), .trip_o(trip_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else begin
      case (phase_q)
        PH_IDLE:    if (start_w) phase_q <= PH_WINDOW;
        PH_WINDOW:  if (close_w) phase_q <= PH_RUNDOWN;
        PH_RUNDOWN: if (trip_w)  phase_q <= PH_IDLE;
        default:                 phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= trip_w;
      if (trip_w) begin
        word_q <= pack_word(coarse_w, fine_w);
        ovf_q  <= fine_ovf_w;
      end
    end
  end

  assign ramp_o  = win_w;
  assign busy_o  = (phase_q != PH_IDLE);
  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;

  AST_BUSY_IGNORES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && hit_rise) |=> $stable(coarse_w)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R5
  AST_VALID_FROM_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(run_w && cmp_i)); // R5
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o) |=> !valid_o); // R8
  AST_RAMP_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_o |-> busy_o); // R3
endmodule

// File: tb/pixel_tstamp_capture_bench.sv
module pixel_tstamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_i = 1'b0;
  logic [9:0]  coarse_i = '0;
  logic        cmp_i = 1'b0;
  logic        ramp_o, busy_o, valid_o, ovf_o;
  logic [17:0] word_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pixel_tstamp_capture u_pixel_tstamp_capture (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .coarse_i(coarse_i), .cmp_i(cmp_i),
    .ramp_o(ramp_o), .busy_o(busy_o), .word_o(word_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] to_gray(input logic [9:0] b);
    return b ^ (b >> 1);
  endfunction

  // one full conversion; inject raises a second hit during run-down and holds it
  task automatic run_conv(input logic [9:0] bin, input int n, input bit inject);
    logic [9:0] g;
    int exp_fine;
    g = to_gray(bin);
    exp_fine = (n > 255) ? 255 : n;
    @(negedge clk);
    coarse_i = g;
    hit_i    = 1'b1;
    @(negedge clk);
    chk(ramp_o == 1'b1, "R3 ramp open", ramp_o, 1);
    chk(busy_o == 1'b1, "R7 busy at hit", busy_o, 1);
    coarse_i = ~g;
    hit_i    = 1'b0;
    @(negedge clk);
    chk(ramp_o == 1'b0, "R3 ramp closed after one period", ramp_o, 0);
    for (int i = 0; i < n; i++) begin
      if (inject && i == 1) begin
        hit_i    = 1'b1;
        coarse_i = g ^ 10'h155;
      end
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R5 no valid before trip", valid_o, 0);
    cmp_i = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b1, "R5 valid after trip", valid_o, 1);
    chk(word_o[17:8] == g, "R2 coarse field", word_o[17:8], g);
    chk(word_o[7:0] == exp_fine[7:0], "R4 fine count", word_o[7:0], exp_fine);
    chk(ovf_o == (n > 255), "R6 overflow flag", ovf_o, (n > 255));
    cmp_i = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R5 valid single cycle", valid_o, 0);
    chk(busy_o == 1'b0, "R7 idle after result", busy_o, 0);
    chk(word_o[17:8] == g, "R5 word holds", word_o[17:8], g);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R7 held hit starts nothing", busy_o, 0);
      chk(ramp_o == 1'b0, "R7 held hit opens no window", ramp_o, 0);
      hit_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(ramp_o == 1'b0, "R1 ramp reset", ramp_o, 0);
    chk(valid_o == 1'b0, "R1 valid reset", valid_o, 0);
    chk(ovf_o == 1'b0, "R1 ovf reset", ovf_o, 0);
    chk(word_o == 18'h0, "R1 word reset", word_o, 0);
  endtask

  task automatic test_idle_cmp();
    @(negedge clk);
    cmp_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R8 cmp idle no valid", valid_o, 0);
      chk(busy_o == 1'b0, "R8 cmp idle not busy", busy_o, 0);
    end
    cmp_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_conv(10'd0, 0, 1'b0);
    run_conv(10'd1023, 1, 1'b0);
    run_conv(10'd513, 37, 1'b0);
    run_conv(10'd700, 254, 1'b0);
    run_conv(10'd341, 255, 1'b0);
    run_conv(10'd170, 256, 1'b0);
    run_conv(10'd99, 300, 1'b0);
    run_conv(10'd612, 6, 1'b1);
    test_idle_cmp();
    run_conv(10'd5, 12, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule